// File: doc/BRIEF.md
# Dual-port RAM with mailbox interrupts

This block is a shared word memory with two independent access ports, left and right, that run from one common clock. Each port has its own select, write/read choice, output enable, address and data lines. Either port can write any word and read any word. Both ports may read the same word in the same cycle. All controls are sampled on the rising edge of the clock. Read data comes out one cycle after the request.

The two highest addresses also serve as mailboxes between the ports. The word just below the top belongs to the left port. When the right port writes it, the left port's interrupt goes low. The left port clears that interrupt by reading the word. The top word belongs to the right port and works the same way with the roles swapped. Each mailbox still stores its data like any other word, so a processor can post a message and raise an interrupt with a single write.

The ports have no back-pressure. Every selected cycle is accepted in the cycle it is presented, and there is no valid/ready handshake. The depth is set by `ADDR_W`: the default is 10 for 1K words, and 13 gives the full 8K-word arrangement with mailboxes at 0x1FFE and 0x1FFF. `DATA_W` defaults to 9.

Top module: `dpram_mailbox`

## Requirements
- R1: While `rst_n` is low at a clock edge, both interrupt outputs go high (inactive) after that edge, both `*_rdrive` outputs go low and both `*_rdata` outputs read zero. Memory contents are not defined by reset.
- R2: A cycle with `*_cs`=1 and `*_wr`=1 stores `*_wdata` at `*_addr`. A cycle with `*_cs`=1, `*_wr`=0 and `*_oe`=1 presents the word at `*_addr` on `*_rdata`, with `*_rdrive`=1, in the cycle after that edge.
- R3: After any edge where the port did not have `*_cs`=1, `*_oe`=1 and `*_wr`=0 together, `*_rdrive` is 0 and `*_rdata` is all zeros.
- R4: Both ports may read the same address in one cycle, and each receives the stored word.
- R5: When both ports write the same address in one cycle, the left port's data is the value stored.
- R6: A right-port write to address 2^ADDR_W-2 drives `l_int_n` low after that edge. A left-port read (`l_cs`=1, `l_wr`=0, with `l_oe` either value) of that address returns it high.
- R7: A left-port write to address 2^ADDR_W-1 drives `r_int_n` low after that edge. A right-port read of that address returns it high.
- R8: If a set and a clear reach the same interrupt in one cycle, the interrupt ends up set (low).
- R9: A flag does not change for any other access. This covers a port writing its own mailbox, the other port reading it, and any other address.
- R10: When one port reads an address that the other port writes in the same cycle, the reader receives the value held before that write.
- R11: Each mailbox address keeps the data written to it, and a read returns that data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst_n | input | 1 | Synchronous reset, active low |
| l_cs | input | 1 | Left port select |
| l_wr | input | 1 | Left port write (1) or read (0) |
| l_oe | input | 1 | Left port read data enable |
| l_addr | input | ADDR_W | Left port word address |
| l_wdata | input | DATA_W | Left port write data |
| l_rdata | output | DATA_W | Left port read data, zero when not driven |
| l_rdrive | output | 1 | Left port read data is being driven |
| l_int_n | output | 1 | Left port interrupt, active low, always driven |
| r_cs | input | 1 | Right port select |
| r_wr | input | 1 | Right port write (1) or read (0) |
| r_oe | input | 1 | Right port read data enable |
| r_addr | input | ADDR_W | Right port word address |
| r_wdata | input | DATA_W | Right port write data |
| r_rdata | output | DATA_W | Right port read data, zero when not driven |
| r_rdrive | output | 1 | Right port read data is being driven |
| r_int_n | output | 1 | Right port interrupt, active low, always driven |

## Verification
The bench builds the block with `ADDR_W`=6 and `DATA_W`=9. At that size every word can be written and read back in a short run. Random traffic also reaches the two mailbox words, at 62 and 63, often enough to hit set and clear in the same cycle and collisions of both ports on one address. A behavioural model is compared against both ports and both interrupts on every clock. Its predictions cover what left-wins writes and read-before-write should produce.

// File: rtl/dpmb_pkg.sv
package dpmb_pkg;

  typedef struct packed {
    logic cs;
    logic wr;
    logic oe;
  } port_ctl_t;

  function automatic logic ctl_is_read(port_ctl_t c);
    return c.cs && !c.wr;
  endfunction

  function automatic logic ctl_is_write(port_ctl_t c);
    return c.cs && c.wr;
  endfunction

  function automatic logic ctl_drives(port_ctl_t c);
    return c.cs && !c.wr && c.oe;
  endfunction

endpackage

// File: rtl/dpmb_array.sv
module dpmb_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9,
  parameter int NPORT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we    [NPORT],
  input  logic              re    [NPORT],
  input  logic [ADDR_W-1:0] addr  [NPORT],
  input  logic [DATA_W-1:0] wdata [NPORT],
  output logic [DATA_W-1:0] rq    [NPORT]
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Reads take the word held before this edge; writes by higher-numbered
  // ports are issued first so port 0 (left) lands last and wins a tie.
  always_ff @(posedge clk) begin
    for (int p = 0; p < NPORT; p++) begin
      if (re[p]) rq[p] <= mem[addr[p]];
    end
    for (int p = NPORT - 1; p >= 0; p--) begin
      if (we[p]) mem[addr[p]] <= wdata[p];
    end
  end

  assert_left_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (we[0] && we[1] && addr[0] == addr[1]) |=> mem[$past(addr[0])] == $past(wdata[0]));

endmodule

// File: rtl/dpmb_irq.sv
module dpmb_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic int_n
);
  logic flag;

  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  assign int_n = ~flag;

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> !int_n);
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> int_n);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && !clr) |=> $stable(int_n));

endmodule

// File: rtl/dpmb_rdgate.sv
module dpmb_rdgate
  import dpmb_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  port_ctl_t         ctl,
  input  logic [DATA_W-1:0] rq,
  output logic [DATA_W-1:0] rdata,
  output logic              rdrive
);
  logic drive_q;

  always_ff @(posedge clk) begin
    if (!rst_n) drive_q <= 1'b0;
    else        drive_q <= ctl_drives(ctl);
  end

  assign rdrive = drive_q;
  assign rdata  = drive_q ? rq : '0;

  assert_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl.cs && ctl.oe && !ctl.wr) |=> (rdata == '0 && !rdrive));

endmodule

// File: rtl/dpram_mailbox.sv
module dpram_mailbox
  import dpmb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_cs,
  input  logic              l_wr,
  input  logic              l_oe,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_rdrive,
  output logic              l_int_n,
  input  logic              r_cs,
  input  logic              r_wr,
  input  logic              r_oe,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_rdrive,
  output logic              r_int_n
);
  localparam int NPORT = 2;
  localparam logic [ADDR_W-1:0] MBX_R = '1;
  localparam logic [ADDR_W-1:0] MBX_L = {{(ADDR_W-1){1'b1}}, 1'b0};

  port_ctl_t         ctl   [NPORT];
  logic [ADDR_W-1:0] addr  [NPORT];
  logic [DATA_W-1:0] wdata [NPORT];
  logic [DATA_W-1:0] rq    [NPORT];
  logic [DATA_W-1:0] rdat  [NPORT];
  logic              we    [NPORT];
  logic              re    [NPORT];
  logic              set   [NPORT];
  logic              clr   [NPORT];
  logic              rdrv  [NPORT];
  logic              intn  [NPORT];

  assign ctl[0]   = '{cs: l_cs, wr: l_wr, oe: l_oe};
  assign ctl[1]   = '{cs: r_cs, wr: r_wr, oe: r_oe};
  assign addr[0]  = l_addr;
  assign addr[1]  = r_addr;
  assign wdata[0] = l_wdata;
  assign wdata[1] = r_wdata;

  dpmb_array #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .NPORT (NPORT)
  ) u_array (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (we),
    .re   (re),
    .addr (addr),
    .wdata(wdata),
    .rq   (rq)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam logic [ADDR_W-1:0] OWN_MBX = (p == 0) ? MBX_L : MBX_R;
    localparam int OTHER = NPORT - 1 - p;

    assign we[p]  = ctl_is_write(ctl[p]);
    assign re[p]  = ctl_is_read(ctl[p]);
    assign set[p] = we[OTHER] && (addr[OTHER] == OWN_MBX);
    assign clr[p] = re[p] && (addr[p] == OWN_MBX);

    dpmb_irq u_irq (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (set[p]),
      .clr  (clr[p]),
      .int_n(intn[p])
    );

    dpmb_rdgate #(
      .DATA_W(DATA_W)
    ) u_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .ctl   (ctl[p]),
      .rq    (rq[p]),
      .rdata (rdat[p]),
      .rdrive(rdrv[p])
    );
  end

  assign l_rdata  = rdat[0];
  assign r_rdata  = rdat[1];
  assign l_rdrive = rdrv[0];
  assign r_rdrive = rdrv[1];
  assign l_int_n  = intn[0];
  assign r_int_n  = intn[1];

  assert_int_known_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown({l_int_n, r_int_n, l_rdrive, r_rdrive}));

  assert_left_mbx_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (r_cs && r_wr && r_addr == MBX_L) |=> !l_int_n);

  assert_right_mbx_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (l_cs && l_wr && l_addr == MBX_R) |=> !r_int_n);

endmodule

// File: tb/dpram_mailbox_tb.sv
module dpram_mailbox_tb;
  localparam int AW    = 6;
  localparam int DW    = 9;
  localparam int DEPTH = 1 << AW;
  localparam int MBX_L = DEPTH - 2;
  localparam int MBX_R = DEPTH - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic          cs [2];
  logic          wr [2];
  logic          oe [2];
  logic [AW-1:0] ad [2];
  logic [DW-1:0] wd [2];
  logic [DW-1:0] l_rdata, r_rdata;
  logic          l_rdrive, r_rdrive, l_int_n, r_int_n;

  always #2 clk = ~clk;

  dpram_mailbox #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .l_cs(cs[0]), .l_wr(wr[0]), .l_oe(oe[0]), .l_addr(ad[0]), .l_wdata(wd[0]),
    .l_rdata(l_rdata), .l_rdrive(l_rdrive), .l_int_n(l_int_n),
    .r_cs(cs[1]), .r_wr(wr[1]), .r_oe(oe[1]), .r_addr(ad[1]), .r_wdata(wd[1]),
    .r_rdata(r_rdata), .r_rdrive(r_rdrive), .r_int_n(r_int_n)
  );

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R1";

  // behavioural reference
  logic [DW-1:0] m_mem [DEPTH];
  bit            m_known [DEPTH];
  bit            m_flag [2];
  logic [DW-1:0] m_rd [2];
  bit            m_drv [2];
  bit            m_rk [2];
  bit            s_set [2];
  bit            s_clr [2];

  initial begin
    for (int i = 0; i < DEPTH; i++) m_known[i] = 1'b0;
    for (int p = 0; p < 2; p++) begin
      cs[p] = 0; wr[p] = 0; oe[p] = 0; ad[p] = '0; wd[p] = '0;
      m_flag[p] = 0; m_drv[p] = 0; m_rd[p] = '0; m_rk[p] = 1;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < 2; p++) begin
        m_flag[p] = 0; m_drv[p] = 0; m_rd[p] = '0; m_rk[p] = 1;
      end
    end else begin
      for (int p = 0; p < 2; p++) begin
        m_drv[p] = cs[p] && !wr[p] && oe[p];
        if (m_drv[p]) begin
          m_rd[p] = m_mem[ad[p]];
          m_rk[p] = m_known[ad[p]];
        end else begin
          m_rd[p] = '0;
          m_rk[p] = 1;
        end
      end
      s_set[0] = cs[1] && wr[1] && (int'(ad[1]) == MBX_L);
      s_clr[0] = cs[0] && !wr[0] && (int'(ad[0]) == MBX_L);
      s_set[1] = cs[0] && wr[0] && (int'(ad[0]) == MBX_R);
      s_clr[1] = cs[1] && !wr[1] && (int'(ad[1]) == MBX_R);
      for (int p = 0; p < 2; p++) begin
        if (s_set[p])      m_flag[p] = 1;
        else if (s_clr[p]) m_flag[p] = 0;
      end
      for (int p = 1; p >= 0; p--) begin
        if (cs[p] && wr[p]) begin
          m_mem[ad[p]] = wd[p];
          m_known[ad[p]] = 1;
        end
      end
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk("l_int_n", 32'(l_int_n), 32'(!m_flag[0]));
    chk("r_int_n", 32'(r_int_n), 32'(!m_flag[1]));
    chk("l_rdrive", 32'(l_rdrive), 32'(m_drv[0]));
    chk("r_rdrive", 32'(r_rdrive), 32'(m_drv[1]));
    if (m_rk[0]) chk("l_rdata", 32'(l_rdata), 32'(m_rd[0]));
    if (m_rk[1]) chk("r_rdata", 32'(r_rdata), 32'(m_rd[1]));
  endtask

  task automatic acc(int p, bit c, bit w, bit o, int a, int d);
    cs[p] = c; wr[p] = w; oe[p] = o; ad[p] = AW'(a); wd[p] = DW'(d);
  endtask

  task automatic idle();
    acc(0, 0, 0, 0, 0, 0);
    acc(1, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired in %s", cur_req);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    @(negedge clk);
    tick(); tick();
    chk("reset l_int_n", 32'(l_int_n), 1);
    chk("reset r_int_n", 32'(r_int_n), 1);
    chk("reset rdata", 32'({l_rdata, r_rdata}), 0);
    rst_n = 1'b1;

    // R2: fill every word from the left, read back from both ports
    cur_req = "R2";
    for (int a = 0; a < DEPTH; a++) begin
      acc(0, 1, 1, 1, a, (a * 37 + 5) & 9'h1ff);
      tick();
    end
    idle();
    for (int a = 0; a < DEPTH; a++) begin
      acc(1, 1, 0, 1, a, 0);
      acc(0, 1, 0, 1, DEPTH - 1 - a, 0);
      tick();
    end
    idle(); tick();
    // R7: left wrote the top word during the fill; right read of it cleared the flag
    cur_req = "R7";
    chk("r_int_n after right read of own mailbox", 32'(r_int_n), 1);

    // R3: gating
    cur_req = "R3";
    acc(1, 1, 0, 0, 3, 0); tick();
    chk("oe low rdrive", 32'(r_rdrive), 0);
    acc(1, 0, 0, 1, 3, 0); tick();
    chk("cs low rdata", 32'(r_rdata), 0);
    acc(1, 1, 1, 1, 20, 9'h0aa); tick();
    chk("write cycle rdrive", 32'(r_rdrive), 0);

    // R4: same-address reads
    cur_req = "R4";
    acc(0, 1, 0, 1, 5, 0); acc(1, 1, 0, 1, 5, 0); tick();
    chk("shared read", 32'(l_rdata), 32'(r_rdata));

    // R5: same-address writes
    cur_req = "R5";
    acc(0, 1, 1, 0, 9, 9'h111); acc(1, 1, 1, 0, 9, 9'h0e2); tick();
    acc(0, 1, 0, 1, 9, 0); acc(1, 0, 0, 0, 0, 0); tick();
    chk("left data kept", 32'(l_rdata), 32'h111);

    // R10: read while the other port writes
    cur_req = "R10";
    acc(0, 1, 1, 0, 12, 9'h155); acc(1, 1, 0, 1, 12, 0); tick();
    chk("old value read", 32'(r_rdata), 32'((12 * 37 + 5) & 9'h1ff));
    idle();

    // R6: left mailbox
    cur_req = "R6";
    acc(1, 1, 1, 0, MBX_L, 9'h1c3); tick();
    chk("l_int_n set", 32'(l_int_n), 0);
    idle();
    acc(0, 1, 0, 0, MBX_L, 0); tick();
    chk("l_int_n cleared", 32'(l_int_n), 1);

    // R7: right mailbox
    cur_req = "R7";
    acc(0, 1, 1, 0, MBX_R, 9'h07e); idle(); acc(0, 1, 1, 0, MBX_R, 9'h07e); tick();
    chk("r_int_n set", 32'(r_int_n), 0);
    idle();
    acc(1, 1, 0, 1, MBX_R, 0); tick();
    chk("r_int_n cleared", 32'(r_int_n), 1);
    // R11: mailbox keeps data
    cur_req = "R11";
    chk("right mailbox data", 32'(r_rdata), 32'h07e);

    // R8: set and clear together
    cur_req = "R8";
    acc(0, 1, 0, 1, MBX_L, 0); acc(1, 1, 1, 0, MBX_L, 9'h0f0); tick();
    chk("set wins", 32'(l_int_n), 0);

    // R9: no effect from other accesses
    cur_req = "R9";
    idle();
    acc(1, 1, 0, 1, MBX_L, 0); tick();
    chk("other-side read keeps flag", 32'(l_int_n), 0);
    acc(1, 0, 0, 0, 0, 0); acc(0, 1, 1, 0, MBX_L, 9'h001); tick();
    chk("own write keeps flag", 32'(l_int_n), 0);
    acc(0, 1, 0, 1, MBX_L, 0); tick();
    cur_req = "R11";
    chk("left mailbox data", 32'(l_rdata), 32'h001);
    cur_req = "R9";
    acc(0, 1, 1, 0, MBX_L, 9'h002); tick();
    chk("own write after clear leaves flag", 32'(l_int_n), 1);
    acc(0, 1, 0, 1, 7, 0); acc(1, 1, 1, 1, 8, 9'h033); tick();
    chk("plain addresses leave flags", 32'({l_int_n, r_int_n}), 3);

    // random mix, addresses biased toward the mailboxes (R2, R6, R7, R8)
    cur_req = "R2";
    for (int n = 0; n < 3000; n++) begin
      for (int p = 0; p < 2; p++) begin
        int a;
        a = ($urandom_range(0, 3) == 0) ? (DEPTH - 1 - int'($urandom_range(0, 1)))
                                        : int'($urandom_range(0, DEPTH - 1));
        acc(p, $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
            $urandom_range(0, 3) != 0, a, int'($urandom_range(0, 511)));
      end
      tick();
    end
    idle(); tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule